// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block holds the frames that a CAN receiver has taken off the bus until the host reads them. Bytes of the frame being received arrive one per cycle on an input stream. Each accepted byte goes into a circular byte store. The stream marks the last byte of each frame, and that byte closes the message. At that point, a separate circular queue records the message's accepted byte count and an overrun flag.

The host sees only the oldest message. It picks a byte offset within that message and reads the byte at that offset combinationally. It also sees the message's length and overrun flag. A release pulse drops the oldest message as a whole: the byte store frees as many bytes as that message holds, and the next message becomes visible. The block also reports how many bytes and how many messages it holds.

The input stream has a valid signal and no ready signal. A bit engine cannot pause the bus, so the store never stalls the sender. A byte that finds no room is discarded, and its message carries the overrun flag.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, `byte_count` and `msg_count` are 0 and `msg_avail` is 0.
- R2: A byte with `in_valid` high is accepted when fewer than DATA_DEPTH bytes and fewer than INFO_DEPTH messages are held. An accepted byte raises `byte_count` by one in the next cycle.
- R3: A valid byte with `in_last` high closes the message. When the info queue is not full, `msg_count` rises by one in the next cycle, and the new entry's length is the number of bytes of that message that were accepted.
- R4: Messages leave oldest first. `rd_len`, `rd_overrun` and `msg_avail` describe the oldest held message.
- R5: A `rel_req` pulse while a message is held removes the oldest message. In the next cycle `byte_count` falls by that message's length and `msg_count` falls by one.
- R6: A `rel_req` while `msg_count` is 0 changes neither count.
- R7: When a byte is accepted in the same cycle as a release, `byte_count` becomes old + 1 - released length.
- R8: A valid byte that arrives while `byte_count` equals DATA_DEPTH is discarded. Its message is stored with `rd_overrun` = 1, and its length counts only the accepted bytes.
- R9: While INFO_DEPTH messages are held, the bytes of a further message are discarded and no entry is added. When that message closes, the newest held message gets its overrun flag set to 1.
- R10: The byte store wraps modulo DATA_DEPTH and the info queue wraps modulo INFO_DEPTH. `rd_data` for offset k is the (k+1)-th byte received in the oldest message, across any wrap.
- R11: `byte_count` never exceeds DATA_DEPTH and `msg_count` never exceeds INFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | This byte ends the message |
| rel_req | input | 1 | Drop the oldest message |
| rd_off | input | $clog2(DATA_DEPTH) | Byte offset within the oldest message |
| rd_data | output | 8 | Byte of the oldest message at `rd_off` |
| rd_len | output | $clog2(DATA_DEPTH+1) | Length of the oldest message |
| rd_overrun | output | 1 | Overrun flag of the oldest message |
| msg_avail | output | 1 | At least one message is held |
| byte_count | output | $clog2(DATA_DEPTH+1) | Bytes held, including a message still open |
| msg_count | output | $clog2(INFO_DEPTH+1) | Closed messages held |

## Verification
The byte path (accepting a byte and closing a message) and the release path (freeing a whole message) can act on `byte_count` and the info queue in the same cycle. Random traffic raises `rel_req` while bytes are streaming. A directed case releases a message on the very cycle a byte is written, and another closes a message while the info queue is full and a release is pending. A bench model applies the release to the state the cycle started with, appends the accepted byte, and then compares both counts, the head length, the flag and the read byte one cycle later.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned RXF_BYTE_W     = 8;
  localparam int unsigned RXF_DATA_DEPTH = 64;
  localparam int unsigned RXF_INFO_DEPTH = 32;

  // Width of a counter that must reach 'depth' inclusive.
  function automatic int unsigned cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rxf_byte_store.sv
module rxf_byte_store #(
  parameter int unsigned DEPTH = rxf_pkg::RXF_DATA_DEPTH,
  parameter int unsigned BW    = rxf_pkg::RXF_BYTE_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = rxf_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  input  logic          free_en,
  input  logic [CW-1:0] free_len,
  input  logic [AW-1:0] rd_off,
  output logic [BW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          has_room
);
  localparam int unsigned SW = CW + 1;
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [BW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, rd_addr, rd_ptr_nxt;
  logic [CW-1:0] count_nxt;

  // Modulo-DEPTH pointer arithmetic: natural wrap when DEPTH is a power of two.
  function automatic logic [AW-1:0] ptr_add(input logic [AW-1:0] p, input logic [CW-1:0] inc);
    logic [SW-1:0] s;
    s = SW'(p) + SW'(inc);
    if (!POW2 && s >= SW'(DEPTH)) s = s - SW'(DEPTH);
    return s[AW-1:0];
  endfunction

  assign rd_addr    = ptr_add(rd_ptr, CW'(rd_off));
  assign rd_data    = mem[rd_addr];
  assign has_room   = (count < CW'(DEPTH));
  assign rd_ptr_nxt = free_en ? ptr_add(rd_ptr, free_len) : rd_ptr;
  assign count_nxt  = count + CW'(wr_en) - (free_en ? free_len : '0);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_add(wr_ptr, CW'(1));
      rd_ptr <= rd_ptr_nxt;
      count  <= count_nxt;
    end
  end
endmodule

// File: rtl/rxf_info_queue.sv
module rxf_info_queue #(
  parameter int unsigned DEPTH = rxf_pkg::RXF_INFO_DEPTH,
  parameter int unsigned LW    = 7,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned QW   = rxf_pkg::cnt_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          push_ovr,
  input  logic          mark_last,
  input  logic          pop,
  output logic [LW-1:0] head_len,
  output logic          head_ovr,
  output logic [QW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [LW-1:0] len_mem [DEPTH];
  logic          ovr_mem [DEPTH];
  logic [AW-1:0] wr_idx, rd_idx, newest_idx;

  function automatic logic [AW-1:0] idx_inc(input logic [AW-1:0] i);
    return (i == LAST_IDX) ? '0 : i + AW'(1);
  endfunction

  assign newest_idx = (wr_idx == '0) ? LAST_IDX : wr_idx - AW'(1);
  assign head_len   = len_mem[rd_idx];
  assign head_ovr   = ovr_mem[rd_idx];
  assign full       = (count == QW'(DEPTH));
  assign empty      = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        len_mem[i] <= '0;
        ovr_mem[i] <= 1'b0;
      end
    end else begin
      if (push) begin
        len_mem[wr_idx] <= push_len;
        ovr_mem[wr_idx] <= push_ovr;
      end
      if (mark_last) ovr_mem[newest_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (push) wr_idx <= idx_inc(wr_idx);
      if (pop)  rd_idx <= idx_inc(rd_idx);
      count <= count + QW'(push) - QW'(pop);
    end
  end
endmodule

// File: rtl/rxf_msg_asm.sv
module rxf_msg_asm #(
  parameter int unsigned LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          has_room,
  input  logic          info_full,
  output logic          byte_acc,
  output logic          push,
  output logic [LW-1:0] push_len,
  output logic          push_ovr,
  output logic          mark_last
);
  logic [LW-1:0] cur_len;
  logic          cur_ovr;
  logic          close, drop;

  assign byte_acc  = in_valid && has_room && !info_full;
  assign drop      = in_valid && !byte_acc;
  assign close     = in_valid && in_last;
  assign push      = close && !info_full;
  assign mark_last = close && info_full;
  assign push_len  = cur_len + LW'(byte_acc);
  assign push_ovr  = cur_ovr || drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_len <= '0;
      cur_ovr <= 1'b0;
    end else if (close) begin
      cur_len <= '0;
      cur_ovr <= 1'b0;
    end else if (in_valid) begin
      cur_len <= push_len;
      cur_ovr <= push_ovr;
    end
  end
endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int unsigned DATA_DEPTH = rxf_pkg::RXF_DATA_DEPTH,
  parameter int unsigned INFO_DEPTH = rxf_pkg::RXF_INFO_DEPTH,
  parameter int unsigned BW         = rxf_pkg::RXF_BYTE_W,
  localparam int unsigned AW        = $clog2(DATA_DEPTH),
  localparam int unsigned LW        = rxf_pkg::cnt_width(DATA_DEPTH),
  localparam int unsigned QW        = rxf_pkg::cnt_width(INFO_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_last,
  input  logic          rel_req,
  input  logic [AW-1:0] rd_off,
  output logic [BW-1:0] rd_data,
  output logic [LW-1:0] rd_len,
  output logic          rd_overrun,
  output logic          msg_avail,
  output logic [LW-1:0] byte_count,
  output logic [QW-1:0] msg_count
);
  logic          has_room, info_full, info_empty;
  logic          byte_acc, push, push_ovr, mark_last, pop;
  logic [LW-1:0] push_len;

  assign pop       = rel_req && !info_empty;
  assign msg_avail = !info_empty;

  rxf_msg_asm #(.LW(LW)) u_asm (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_last(in_last),
    .has_room(has_room), .info_full(info_full),
    .byte_acc(byte_acc), .push(push), .push_len(push_len),
    .push_ovr(push_ovr), .mark_last(mark_last)
  );

  rxf_byte_store #(.DEPTH(DATA_DEPTH), .BW(BW)) u_bytes (
    .clk(clk), .rst_n(rst_n),
    .wr_en(byte_acc), .wr_data(in_data),
    .free_en(pop), .free_len(rd_len),
    .rd_off(rd_off), .rd_data(rd_data),
    .count(byte_count), .has_room(has_room)
  );

  rxf_info_queue #(.DEPTH(INFO_DEPTH), .LW(LW)) u_info (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_len(push_len), .push_ovr(push_ovr),
    .mark_last(mark_last), .pop(pop),
    .head_len(rd_len), .head_ovr(rd_overrun),
    .count(msg_count), .full(info_full), .empty(info_empty)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DATA_DEPTH = 64,
  parameter int unsigned INFO_DEPTH = 32,
  parameter int unsigned LW         = 7,
  parameter int unsigned QW         = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          rel_req,
  input logic [LW-1:0] rd_len,
  input logic [LW-1:0] byte_count,
  input logic [QW-1:0] msg_count
);
  // R11
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(byte_count) <= int'(DATA_DEPTH));

  // R11
  msg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(msg_count) <= int'(INFO_DEPTH));

  // R6
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_count == '0 && !in_valid) |=> ($stable(byte_count) && $stable(msg_count)));

  // R2
  byte_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rel_req && int'(byte_count) < int'(DATA_DEPTH) && int'(msg_count) < int'(INFO_DEPTH))
    |=> int'(byte_count) == int'($past(byte_count)) + 1);

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rel_req && int'(byte_count) == int'(DATA_DEPTH)) |=> int'(byte_count) == int'(DATA_DEPTH));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && msg_count != '0 && !in_valid)
    |=> (int'(byte_count) == int'($past(byte_count)) - int'($past(rd_len))
         && int'(msg_count) == int'($past(msg_count)) - 1));
endmodule

bind rx_msg_fifo rxf_chk #(
  .DATA_DEPTH(DATA_DEPTH), .INFO_DEPTH(INFO_DEPTH), .LW(LW), .QW(QW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rel_req(rel_req),
  .rd_len(rd_len), .byte_count(byte_count), .msg_count(msg_count)
);

// File: tb/tb_rx_msg_fifo.sv
module tb_rx_msg_fifo;
  localparam int DD = 64;
  localparam int ID = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, rel_req = 1'b0;
  logic [7:0] in_data = '0;
  logic [5:0] rd_off = '0;
  logic [7:0] rd_data;
  logic [6:0] rd_len, byte_count;
  logic [5:0] msg_count;
  logic       rd_overrun, msg_avail;

  int checks = 0;
  int fails  = 0;

  // Bench model: all held bytes in order, plus per-message info.
  logic [7:0] mq[$];
  int         lenq[$];
  bit         ovrq[$];
  int         cur_len = 0;
  bit         cur_ovr = 0;

  always #2.5 clk = ~clk;

  rx_msg_fifo dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .rel_req(rel_req), .rd_off(rd_off), .rd_data(rd_data),
    .rd_len(rd_len), .rd_overrun(rd_overrun), .msg_avail(msg_avail),
    .byte_count(byte_count), .msg_count(msg_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_byte(input int off);
    return int'(mq[off]);
  endfunction

  function automatic string cycle_tag(input bit v, input bit r, input bit acc,
                                      input bit relv, input int pre_msgs, input bit l);
    if (relv && acc)         return "R7";
    if (relv)                return "R5";
    if (r)                   return "R6";
    if (v && !acc && pre_msgs >= ID) return "R9";
    if (v && !acc)           return "R8";
    if (v && l)              return "R3";
    return "R2";
  endfunction

  task automatic step(input bit v, input logic [7:0] d, input bit l, input bit r, input int off);
    int pre_bytes, pre_msgs, n;
    bit acc, relv;
    string tag;
    in_valid = v; in_data = d; in_last = l; rel_req = r; rd_off = 6'(off);
    pre_bytes = mq.size();
    pre_msgs  = lenq.size();
    acc  = v && pre_bytes < DD && pre_msgs < ID;
    relv = r && pre_msgs > 0;
    tag  = cycle_tag(v, r, acc, relv, pre_msgs, l);
    if (relv) begin
      n = lenq.pop_front();
      void'(ovrq.pop_front());
      for (int i = 0; i < n; i++) void'(mq.pop_front());
    end
    if (acc) begin
      mq.push_back(d);
      cur_len++;
    end else if (v) cur_ovr = 1;
    if (v && l) begin
      if (pre_msgs < ID) begin
        lenq.push_back(cur_len);
        ovrq.push_back(cur_ovr);
      end else ovrq[ovrq.size()-1] = 1;
      cur_len = 0;
      cur_ovr = 0;
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "byte_count", int'(byte_count), mq.size());
    chk(tag, "msg_count", int'(msg_count), lenq.size());
    chk("R4", "msg_avail", int'(msg_avail), int'(lenq.size() > 0));
    if (lenq.size() > 0) begin
      chk("R3", "rd_len", int'(rd_len), lenq[0]);
      chk("R8/R9", "rd_overrun", int'(rd_overrun), int'(ovrq[0]));
      if (off < lenq[0]) chk("R4/R10", "rd_data", int'(rd_data), exp_byte(off));
    end
  endtask

  task automatic rnd_phase(input int cycles, input int p_rel);
    for (int c = 0; c < cycles; c++) begin
      bit v, l, r;
      v = ($urandom % 100) < 60;
      l = ($urandom % 100) < 20;
      r = ($urandom % 100) < p_rel;
      step(v, 8'($urandom), l, r, int'($urandom % 16));
    end
  endtask

  task automatic drain();
    for (int c = 0; c < 40; c++) step(0, 8'h00, 0, 1, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "byte_count", int'(byte_count), 0);
    chk("R1", "msg_count", int'(msg_count), 0);
    chk("R1", "msg_avail", int'(msg_avail), 0);
    // R6 release on empty
    step(0, 8'h00, 0, 1, 0);
    // Random traffic (R2..R5, R7, R10)
    rnd_phase(1500, 15);
    drain();
    // R8: fill byte store with 10-byte messages, no release
    for (int c = 0; c < 80; c++) step(1, 8'(c), (c % 10) == 9, 0, c % 10);
    step(1, 8'hAA, 1, 0, 0);
    drain();
    // R9: 1-byte messages until the info queue is full, then more
    for (int c = 0; c < 34; c++) step(1, 8'(8'h40 + c), 1, 0, 0);
    // Two-byte message while full, closing with a release in the same cycle
    step(1, 8'h77, 0, 0, 0);
    step(1, 8'h78, 1, 1, 0);
    // R7: partial message byte written while releasing
    step(1, 8'h90, 0, 1, 0);
    step(1, 8'h91, 1, 1, 0);
    drain();
    rnd_phase(1500, 20);
    drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule